// File: doc/BRIEF.md
# Metastable Latch Array Sampling Controller

This block drives an array of cross-coupled latch entropy cells through repeated two-phase periods and folds their outputs into one random bit per period. In the hold phase, the shared release line stays low. This forces every cell into its reset condition. In the settle phase, the line is high and each cell falls into one of its two complementary stable states. At the end of the settle phase, the cell outputs are captured into a sample register. A registered XOR tree then reduces the sample to a single bit, and the bit is marked by a one-cycle valid strobe.

The hold length and the settle length are separate cycle counts, so the period and the duty ratio can be set independently. For example, a hold of 1 cycle and a settle of 4 cycles gives a 50 ns period at 100 MHz. Inside the block, the cells are a behavioural stand-in: each cell resolves to a pseudo-random value drawn from a seeded generator. A low enable returns the release line low and stops sequencing.

Top module: `mla_sampler`

## Requirements
- R1: While reset is low, and on the first cycle after it: `cell_release` is 0, `bit_valid` is 0, `rand_bit` is 0 and `sample` is all zeros.
- R2: While enabled, `cell_release` repeats a pattern of low for the hold count of cycles, then high for the settle count of cycles.
- R3: A hold or settle count of zero is treated as one cycle.
- R4: Both counts are taken at the first cycle of each period. A change that arrives during a period first shows in the following period.
- R5: When `en` is low, `cell_release` is low from the next cycle on. A period that is cut short this way produces no `bit_valid`.
- R6: `sample` is loaded only at the clock edge that ends a completed settle phase, which is the same edge at which `cell_release` falls. At all other edges it holds its value.
- R7: When `bit_valid` is 1, `rand_bit` equals the XOR of all bits that `sample` held L cycles earlier. L is the number of 6-input reduction levels, ceil(log6 N_CELLS), which is 0 when N_CELLS is 1.
- R8: `bit_valid` is high for exactly one cycle per completed period. Consecutive pulses are spaced by hold plus settle cycles.
- R9: Cells resolve afresh in each period. The rails of a released cell are complementary. A held cell shows both rails at the forced level: 1 when NOR_STYLE=0, 0 when NOR_STYLE=1. Over many periods, `rand_bit` takes both values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run sequencing when high |
| init_cycles | input | CNT_W | Hold-phase length in cycles (0 acts as 1) |
| settle_cycles | input | CNT_W | Settle-phase length in cycles (0 acts as 1) |
| cell_release | output | 1 | Shared release line to the cells (low = hold) |
| sample | output | N_CELLS | Cell outputs captured at the end of the settle phase |
| rand_bit | output | 1 | XOR of the captured sample |
| bit_valid | output | 1 | One-cycle strobe marking `rand_bit` |

## Verification
The bench builds the block with N_CELLS=13 and CNT_W=8. With 13 cells the tree has two levels, and the second level has an incomplete group of three inputs. A latency of two cycles lets successive samples overlap in the pipeline when the period is as short as two cycles. The small count width keeps settings such as zero, one, and a mid-period change within a few hundred cycles.

// File: rtl/mla_pkg.sv
// Shared types and elaboration-time helpers for the latch-array sampler.
// Assumes only constant arguments are passed to the functions.
package mla_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HOLD   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_t;

    // Number of reduction levels needed to fold n signals with a given fan-in.
    function automatic int xor_levels(int n, int fanin);
        int w;
        int l;
        w = n;
        l = 0;
        while (w > 1) begin
            w = (w + fanin - 1) / fanin;
            l++;
        end
        return l;
    endfunction

    // Width of reduction level s (level 0 is the raw input).
    function automatic int level_width(int n, int fanin, int s);
        int w;
        w = n;
        for (int i = 0; i < s; i++) w = (w + fanin - 1) / fanin;
        return w;
    endfunction

    // Per-cell tap mask into the shared generator; never zero.
    function automatic logic [31:0] cell_tap(int idx);
        logic [31:0] m;
        m = 32'(idx + 1) * 32'h9E37_79B9;
        m = m ^ (m >> 15);
        m[idx % 32] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mla_seq.sv
// Phase sequencer: runs hold and settle phases from per-period latched counts,
// drives the shared release line and flags the capture cycle.
// Assumes counts of zero mean one cycle; en low aborts the current period.
module mla_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] init_cycles,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             release_o,
    output logic             capture_o
);
    import mla_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_len;
    logic [CNT_W-1:0] settle_len;
    logic [CNT_W-1:0] hold_in;
    logic [CNT_W-1:0] settle_in;
    logic             rel_q;

    // Clamp zero-length requests to one cycle.
    always_comb begin
        hold_in   = (init_cycles   == '0) ? ONE : init_cycles;
        settle_in = (settle_cycles == '0) ? ONE : settle_cycles;
    end

    // Capture on the last settle cycle of a period that is still enabled.
    assign capture_o = (phase == PH_SETTLE) && (cnt == settle_len) && en;
    assign release_o = rel_q;

    // Phase and counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= ONE;
            hold_len   <= ONE;
            settle_len <= ONE;
            rel_q      <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    rel_q <= 1'b0;
                    if (en) begin
                        phase      <= PH_HOLD;
                        cnt        <= ONE;
                        hold_len   <= hold_in;
                        settle_len <= settle_in;
                    end
                end
                PH_HOLD: begin
                    if (!en) begin
                        phase <= PH_IDLE;
                        rel_q <= 1'b0;
                    end else if (cnt == hold_len) begin
                        phase <= PH_SETTLE;
                        cnt   <= ONE;
                        rel_q <= 1'b1;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_SETTLE: begin
                    if (!en) begin
                        phase <= PH_IDLE;
                        rel_q <= 1'b0;
                    end else if (cnt == settle_len) begin
                        phase      <= PH_HOLD;
                        cnt        <= ONE;
                        hold_len   <= hold_in;
                        settle_len <= settle_in;
                        rel_q      <= 1'b0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    rel_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mla_cells.sv
// Behavioural stand-in for the cross-coupled latch cells. While release is
// low both rails sit at the forced level; once released, each cell shows a
// value drawn from a seeded 32-bit LFSR during the preceding hold.
// Assumes release stays high long enough to be sampled (one cycle minimum).
module mla_cells #(
    parameter int          N         = 320,
    parameter logic [31:0] SEED      = 32'h1ACE_B00C,
    parameter bit          NOR_STYLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         release_i,
    output logic [N-1:0] q_o,
    output logic [N-1:0] qb_o
);
    localparam logic [N-1:0] FORCED = {N{~NOR_STYLE}};

    logic [31:0]  lfsr;
    logic [N-1:0] draw_next;
    logic [N-1:0] draw;

    // Free-running maximal-length generator (taps 32,22,2,1).
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= SEED | 32'h1;
        else        lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end

    // Each cell hashes its own subset of generator bits.
    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam logic [31:0] TAP = mla_pkg::cell_tap(i);
        assign draw_next[i] = ^(lfsr & TAP);
    end

    // Draws refresh while held and freeze once the cells are released.
    always_ff @(posedge clk) begin
        if (!rst_n)          draw <= '0;
        else if (!release_i) draw <= draw_next;
    end

    // Rails: forced level while held, complementary values while released.
    assign q_o  = release_i ? draw  : FORCED;
    assign qb_o = release_i ? ~draw : FORCED;

endmodule

// File: rtl/mla_xor_tree.sv
// Registered XOR reduction with fan-in FANIN per level; one register per level.
// Latency is xor_levels(N, FANIN) cycles; a valid bit travels alongside.
module mla_xor_tree #(
    parameter int N     = 320,
    parameter int FANIN = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] in_bits,
    output logic         out_bit,
    output logic         out_valid
);
    localparam int LV = mla_pkg::xor_levels(N, FANIN);

    if (LV == 0) begin : g_pass
        assign out_bit   = in_bits[0];
        assign out_valid = in_valid;
    end else begin : g_tree
        for (genvar s = 0; s < LV; s++) begin : g_lvl
            localparam int WI = mla_pkg::level_width(N, FANIN, s);
            localparam int WO = mla_pkg::level_width(N, FANIN, s + 1);
            logic [WI-1:0]       prev;
            logic                prev_v;
            logic [WO*FANIN-1:0] padded;
            logic [WO-1:0]       nxt;
            logic [WO-1:0]       q;
            logic                v;

            if (s == 0) begin : g_src
                assign prev   = in_bits;
                assign prev_v = in_valid;
            end else begin : g_src
                assign prev   = g_lvl[s-1].q;
                assign prev_v = g_lvl[s-1].v;
            end

            // Fold each group of FANIN inputs, zero-padding the last group.
            always_comb begin
                padded = '0;
                padded[WI-1:0] = prev;
                for (int j = 0; j < WO; j++) nxt[j] = ^padded[j*FANIN +: FANIN];
            end

            // Level register with its valid flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                    v <= 1'b0;
                end else begin
                    q <= nxt;
                    v <= prev_v;
                end
            end
        end
        assign out_bit   = g_lvl[LV-1].q[0];
        assign out_valid = g_lvl[LV-1].v;
    end

endmodule

// File: rtl/mla_sampler.sv
// Top of the latch-array sampler: sequencer, cell array, sample register and
// registered XOR tree. One rand_bit/bit_valid pair per completed period,
// 1 + ceil(log6 N_CELLS) cycles after the capture cycle.
module mla_sampler #(
    parameter int          N_CELLS   = 320,
    parameter int          CNT_W     = 8,
    parameter logic [31:0] SEED      = 32'h1ACE_B00C,
    parameter bit          NOR_STYLE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [CNT_W-1:0]   init_cycles,
    input  logic [CNT_W-1:0]   settle_cycles,
    output logic               cell_release,
    output logic [N_CELLS-1:0] sample,
    output logic               rand_bit,
    output logic               bit_valid
);
    logic               cap;
    logic               smp_vld;
    logic [N_CELLS-1:0] cell_q;
    logic [N_CELLS-1:0] cell_qb;

    mla_seq #(.CNT_W(CNT_W)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .init_cycles   (init_cycles),
        .settle_cycles (settle_cycles),
        .release_o     (cell_release),
        .capture_o     (cap)
    );

    mla_cells #(.N(N_CELLS), .SEED(SEED), .NOR_STYLE(NOR_STYLE)) i_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (cell_release),
        .q_o       (cell_q),
        .qb_o      (cell_qb)
    );

    // Output register: take the cell values at the end of the settle phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample  <= '0;
            smp_vld <= 1'b0;
        end else begin
            if (cap) sample <= cell_q;
            smp_vld <= cap;
        end
    end

    mla_xor_tree #(.N(N_CELLS), .FANIN(6)) i_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_vld),
        .in_bits   (sample),
        .out_bit   (rand_bit),
        .out_valid (bit_valid)
    );

endmodule

// File: rtl/mla_sampler_chk.sv
// Property checker for mla_sampler, attached by bind below.
module mla_sampler_chk #(
    parameter int N         = 320,
    parameter bit NOR_STYLE = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         cell_release,
    input logic         capture,
    input logic [N-1:0] cell_q,
    input logic [N-1:0] cell_qb,
    input logic [N-1:0] sample,
    input logic         bit_valid
);
    localparam logic [N-1:0] FORCED_VEC = {N{~NOR_STYLE}};

    p_off_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cell_release);

    p_capture_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> cell_release);

    p_capture_ends_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !cell_release);

    p_sample_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(sample));

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    p_rails_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cell_release |-> (&(cell_q ^ cell_qb)));

    p_rails_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_release |-> (cell_q == FORCED_VEC && cell_qb == FORCED_VEC));

endmodule

bind mla_sampler mla_sampler_chk #(.N(N_CELLS), .NOR_STYLE(NOR_STYLE)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cell_release (cell_release),
    .capture      (cap),
    .cell_q       (cell_q),
    .cell_qb      (cell_qb),
    .sample       (sample),
    .bit_valid    (bit_valid)
);

// File: tb/test_mla_sampler.sv
// Directed bench for mla_sampler with 13 cells (two reduction levels).
module test_mla_sampler;
    localparam int CLK_P = 10;
    localparam int NC    = 13;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] init_cycles = '0;
    logic [CW-1:0] settle_cycles = '0;
    logic          cell_release;
    logic [NC-1:0] sample;
    logic          rand_bit;
    logic          bit_valid;

    mla_sampler #(.N_CELLS(NC), .CNT_W(CW), .SEED(32'h0BAD_5EED)) i_mla_sampler (
        .clk(clk), .rst_n(rst_n), .en(en),
        .init_cycles(init_cycles), .settle_cycles(settle_cycles),
        .cell_release(cell_release), .sample(sample),
        .rand_bit(rand_bit), .bit_valid(bit_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reduction depth for 6-input levels, from the requirement alone.
    function automatic int depth6(int n);
        int w = n, l = 0;
        while (w > 1) begin w = (w + 5) / 6; l++; end
        return l;
    endfunction
    localparam int LAT = depth6(NC);

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor state, updated at every falling edge.
    bit            mon_on = 0;
    int            cyc = 0, run = 0, last_low = 0, last_high = 0;
    int            n_rise = 0, n_fall = 0, n_valid = 0;
    int            last_gap = 0, last_vcyc = 0, ones = 0, zeros = 0;
    logic          prev_rel = 1'b0;
    logic [NC-1:0] prev_sample = '0;
    logic [NC-1:0] hist [64];

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            hist[cyc % 64] = sample;
            if (cell_release == prev_rel) run++;
            else begin
                if (prev_rel) begin last_high = run; n_fall++; end
                else          begin last_low  = run; n_rise++; end
                run = 1;
            end
            if (sample != prev_sample)  // R6: load only where release falls
                check(prev_rel && !cell_release, "R6", "sample changed off the capture edge",
                      int'(cell_release), 0);
            if (bit_valid) begin
                n_valid++;
                check(rand_bit == ^hist[(cyc - LAT) % 64], "R7", "rand_bit vs xor of sample",
                      int'(rand_bit), int'(^hist[(cyc - LAT) % 64]));
                last_gap  = cyc - last_vcyc;
                last_vcyc = cyc;
                if (rand_bit) ones++; else zeros++;
            end
            prev_rel    = cell_release;
            prev_sample = sample;
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask
    task automatic wait_fall(); int c = n_fall; while (n_fall == c) step(); endtask
    task automatic wait_rise(); int c = n_rise; while (n_rise == c) step(); endtask
    task automatic wait_valid(); int c = n_valid; while (n_valid == c) step(); endtask

    task automatic t_reset();
        step(4);
        check(cell_release == 0, "R1", "release in reset", int'(cell_release), 0);
        check(bit_valid == 0, "R1", "valid in reset", int'(bit_valid), 0);
        check(rand_bit == 0, "R1", "rand_bit in reset", int'(rand_bit), 0);
        check(sample == '0, "R1", "sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        mon_on = 1;
        step();
        check(cell_release == 0 && bit_valid == 0, "R1", "outputs after reset",
              int'({cell_release, bit_valid}), 0);
    endtask

    // R2 / R3 / R8: run a setting and measure the release pattern and strobe spacing.
    task automatic t_period(int ih, int st, int exp_h, int exp_s, string req);
        init_cycles = CW'(ih);
        settle_cycles = CW'(st);
        en = 1'b1;
        repeat (3) wait_fall();
        check(last_low == exp_h, req, "hold length", last_low, exp_h);
        check(last_high == exp_s, req, "settle length", last_high, exp_s);
        wait_valid();
        wait_valid();
        check(last_gap == exp_h + exp_s, "R8", "strobe spacing", last_gap, exp_h + exp_s);
    endtask

    // R4: change counts while settling; the current period keeps its counts.
    task automatic t_midchange();
        t_period(2, 3, 2, 3, "R2");
        wait_rise();
        init_cycles = 8'd5;
        settle_cycles = 8'd6;
        wait_fall();
        check(last_high == 3, "R4", "settle of running period", last_high, 3);
        wait_rise();
        check(last_low == 5, "R4", "hold of next period", last_low, 5);
        wait_fall();
        check(last_high == 6, "R4", "settle of next period", last_high, 6);
    endtask

    // R5: drop enable mid-settle; release low next cycle, no strobe, stays idle.
    task automatic t_disable();
        int nv, nr;
        t_period(2, 6, 2, 6, "R2");
        wait_rise();
        step(2);
        en = 1'b0;
        nv = n_valid;
        nr = n_rise;
        step();
        check(cell_release == 0, "R5", "release after en low", int'(cell_release), 0);
        step(12);
        check(n_valid == nv, "R5", "strobes while off", n_valid - nv, 0);
        check(n_rise == nr && cell_release == 0, "R5", "release rises while off", n_rise - nr, 0);
    endtask

    // R9: many periods give both values of rand_bit.
    task automatic t_random();
        init_cycles = 8'd1;
        settle_cycles = 8'd4;
        en = 1'b1;
        ones = 0;
        zeros = 0;
        repeat (60) wait_valid();
        check(ones > 0, "R9", "ones seen", ones, 1);
        check(zeros > 0, "R9", "zeros seen", zeros, 1);
    endtask

    initial begin
        t_reset();
        t_period(1, 4, 1, 4, "R2");
        t_period(3, 2, 3, 2, "R2");
        t_period(2, 1, 2, 1, "R2");
        t_period(1, 1, 1, 1, "R2");
        t_period(0, 0, 1, 1, "R3");
        t_period(0, 3, 1, 3, "R3");
        t_period(4, 0, 4, 1, "R3");
        t_midchange();
        t_disable();
        t_random();
        check(n_valid > 0, "R7", "xor comparisons made", n_valid, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule